// File: doc/BRIEF.md
# Floating-Point Register Specifier Decoder

This block sits in the decode stage of a floating-point unit. On every decode strobe it takes the three 5-bit register specifiers of an instruction: two sources and one destination. It turns each one into a 6-bit physical index into a register file of 64 single-width slots. How it does so depends on the operand size the decoder supplies: none, single, double or quad. For double and quad operands, the low specifier bit selects the upper half of the file. A quad specifier whose bit 1 is set is illegal and aborts the operation.

The block also holds the lazy-context state of the register file. It keeps one dirty bit for each 32-slot half and one enable bit for the unit. A source in a half that has not yet been written must be read as zero. The first accepted destination write into a clean half asks the storage to clear that whole half in one cycle. The first accepted destination write of all also sets the enable bit and asks for the graphics status register to be cleared.

Before any of this takes effect, the block compares the trap-type field from the status register with the type the operation expects. A mismatch rejects the operation, unless the operation entered through the illegal-instruction path. The per-operand outputs, the accept and reject flags and the trap-type write are all combinational and valid in the strobe cycle. The state bits change at the following clock edge.

Top module: `fp_regspec_decoder`

## Requirements
- R1: The source-1 specifier is taken from instruction bits 18:14, source-2 from bits 4:0 and the destination from bits 29:25.
- R2: The size encoding is 0 none, 1 single, 2 double, 3 quad. For a single operand the index equals the specifier and the upper flag is 0. For a size-none operand the index is 0 and the upper and error flags are 0.
- R3: For a double or quad operand the index is {spec[0], spec[4:1], 0}, and the upper flag equals index bit 5.
- R4: A quad operand whose specifier has bit 1 set raises that operand's error flag during the strobe. If the trap-type check passes, the operation is rejected with ftt_we=1 and ftt_new=6.
- R5: With from_illegal low and stat_ftt different from exp_ftt, a strobe gives op_reject=1, op_accept=0, ftt_we=0, and no clear request and no state change.
- R6: When the trap-type check passes and no operand is illegal, a strobe gives op_accept=1, op_reject=0, ftt_we=1 and ftt_new=0.
- R7: During a strobe, a source of non-none size reports zero-read when the dirty bit of its half is clear, judged on the state held before that strobe.
- R8: An accepted operation with a non-none destination in a half whose dirty bit is clear raises the clear request for exactly that half in the strobe cycle. The dirty bit is set from the next cycle and never falls afterwards. A later write to the same half raises no clear request.
- R9: The first accepted destination write while fp_enabled is 0 pulses gsr_clr in the strobe cycle and sets fp_enabled from the next cycle. Later writes give no gsr_clr.
- R10: After reset both dirty bits and fp_enabled are 0, and no clear or gsr request is raised.
- R11: A rejected operation, or an accepted one with a size-none destination, raises no clear or gsr request and leaves the dirty and enable bits unchanged.
- R12: With from_illegal high, the trap-type comparison is skipped and the operation proceeds as if it matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_strobe | input | 1 | Decode strobe: an instruction is presented |
| instr | input | 32 | Instruction word |
| rs1_size | input | 2 | Source-1 operand size |
| rs2_size | input | 2 | Source-2 operand size |
| rd_size | input | 2 | Destination operand size |
| exp_ftt | input | 3 | Trap type the operation expects |
| stat_ftt | input | 3 | Trap-type field currently in the status register |
| from_illegal | input | 1 | Operation entered through the illegal-instruction path |
| rs1_idx | output | 6 | Source-1 physical slot index |
| rs1_upper | output | 1 | Source-1 lies in the upper half |
| rs1_err | output | 1 | Source-1 illegal quad specifier |
| rs1_zero | output | 1 | Source-1 must be read as zero |
| rs2_idx | output | 6 | Source-2 physical slot index |
| rs2_upper | output | 1 | Source-2 lies in the upper half |
| rs2_err | output | 1 | Source-2 illegal quad specifier |
| rs2_zero | output | 1 | Source-2 must be read as zero |
| rd_idx | output | 6 | Destination physical slot index |
| rd_upper | output | 1 | Destination lies in the upper half |
| rd_err | output | 1 | Destination illegal quad specifier |
| op_accept | output | 1 | Operation may proceed |
| op_reject | output | 1 | Operation is aborted |
| ftt_we | output | 1 | Write ftt_new into the status trap-type field |
| ftt_new | output | 3 | New trap-type value |
| clr_lower | output | 1 | Bulk clear request for slots 0 to 31 |
| clr_upper | output | 1 | Bulk clear request for slots 32 to 63 |
| gsr_clr | output | 1 | Clear request for the graphics status register |
| fp_enabled | output | 1 | Unit enable bit |
| dirty_lower | output | 1 | Lower half has been written |
| dirty_upper | output | 1 | Upper half has been written |

## Verification
A source zero-read and a destination bulk clear can fall in the same cycle when one instruction reads and writes the same clean half. The bench provokes this right after reset with a single-size source and a single-size destination, both in the lower half. It then expects rs1_zero and clr_lower high together in the strobe cycle, because the zero-read is judged on the state before the strobe. Repeating the same instruction must then show neither flag, while a source in the still-clean upper half continues to read as zero.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;
    localparam int SPEC_W = 5;
    localparam int IDX_W  = SPEC_W + 1;
    localparam int FTT_W  = 3;

    typedef enum logic [1:0] {
        OPSZ_NONE = 2'd0,
        OPSZ_SGL  = 2'd1,
        OPSZ_DBL  = 2'd2,
        OPSZ_QUAD = 2'd3
    } opsz_e;

    typedef struct packed {
        logic dirty_lo;
        logic dirty_hi;
        logic fp_en;
    } trk_state_t;

    localparam trk_state_t TRK_RESET = '{dirty_lo: 1'b0, dirty_hi: 1'b0, fp_en: 1'b0};
endpackage

// File: rtl/fpdec_spec_map.sv
module fpdec_spec_map #(
    parameter int INSN_W    = 32,
    parameter int FIELD_LSB = 0,
    parameter int SPEC_W    = 5
) (
    input  logic [INSN_W-1:0] instr,
    input  logic [1:0]        size,
    input  logic              strobe,
    output logic [SPEC_W:0]   idx,
    output logic              upper,
    output logic              bad,
    output logic              used
);
    import fpdec_pkg::*;

    localparam int HALF_BIT = SPEC_W;

    logic [SPEC_W-1:0] spec;
    opsz_e             sz;

    assign spec = instr[FIELD_LSB +: SPEC_W];
    assign sz   = opsz_e'(size);

    always_comb begin
        unique case (sz)
            OPSZ_NONE: idx = '0;
            OPSZ_SGL:  idx = {1'b0, spec};
            default:   idx = {spec[0], spec[SPEC_W-1:1], 1'b0};
        endcase
        upper = idx[HALF_BIT];
        used  = (sz != OPSZ_NONE);
        bad   = strobe && (sz == OPSZ_QUAD) && spec[1];
    end
endmodule

// File: rtl/fpdec_ftt_check.sv
module fpdec_ftt_check #(
    parameter int FTT_W      = 3,
    parameter int FTT_BADREG = 6
) (
    input  logic             strobe,
    input  logic [FTT_W-1:0] exp_ftt,
    input  logic [FTT_W-1:0] stat_ftt,
    input  logic             from_illegal,
    input  logic             any_bad,
    output logic             accept,
    output logic             reject,
    output logic             ftt_we,
    output logic [FTT_W-1:0] ftt_new
);
    logic type_ok;

    always_comb begin
        type_ok = from_illegal || (stat_ftt == exp_ftt);
        ftt_we  = strobe && type_ok;
        ftt_new = any_bad ? FTT_W'(FTT_BADREG) : '0;
        accept  = strobe && type_ok && !any_bad;
        reject  = strobe && !(type_ok && !any_bad);
    end
endmodule

// File: rtl/fpdec_half_track.sv
module fpdec_half_track #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic               wr_accept,
    input  logic               rd_used,
    input  logic               rd_upper,
    input  logic [NUM_SRC-1:0] src_used,
    input  logic [NUM_SRC-1:0] src_upper,
    output logic [NUM_SRC-1:0] src_zero,
    output logic               clr_lo,
    output logic               clr_hi,
    output logic               gsr_clr,
    output logic               dirty_lo,
    output logic               dirty_hi,
    output logic               fp_en
);
    import fpdec_pkg::*;

    trk_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        clr_lo  = 1'b0;
        clr_hi  = 1'b0;
        gsr_clr = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            src_zero[i] = strobe && src_used[i] &&
                          !(src_upper[i] ? st_q.dirty_hi : st_q.dirty_lo);
        end
        if (wr_accept && rd_used) begin
            if (!st_q.fp_en) begin
                st_d.fp_en    = 1'b1;
                st_d.dirty_lo = 1'b0;
                st_d.dirty_hi = 1'b0;
                gsr_clr       = 1'b1;
            end
            if (rd_upper) begin
                if (!st_d.dirty_hi) begin
                    clr_hi        = 1'b1;
                    st_d.dirty_hi = 1'b1;
                end
            end else begin
                if (!st_d.dirty_lo) begin
                    clr_lo        = 1'b1;
                    st_d.dirty_lo = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TRK_RESET;
        else        st_q <= st_d;
    end

    assign dirty_lo = st_q.dirty_lo;
    assign dirty_hi = st_q.dirty_hi;
    assign fp_en    = st_q.fp_en;
endmodule

// File: rtl/fp_regspec_decoder.sv
module fp_regspec_decoder #(
    parameter int INSN_W     = 32,
    parameter int SPEC_W     = 5,
    parameter int FTT_W      = 3,
    parameter int FTT_BADREG = 6,
    parameter int RS1_LSB    = 14,
    parameter int RS2_LSB    = 0,
    parameter int RD_LSB     = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_strobe,
    input  logic [INSN_W-1:0] instr,
    input  logic [1:0]        rs1_size,
    input  logic [1:0]        rs2_size,
    input  logic [1:0]        rd_size,
    input  logic [FTT_W-1:0]  exp_ftt,
    input  logic [FTT_W-1:0]  stat_ftt,
    input  logic              from_illegal,
    output logic [SPEC_W:0]   rs1_idx,
    output logic              rs1_upper,
    output logic              rs1_err,
    output logic              rs1_zero,
    output logic [SPEC_W:0]   rs2_idx,
    output logic              rs2_upper,
    output logic              rs2_err,
    output logic              rs2_zero,
    output logic [SPEC_W:0]   rd_idx,
    output logic              rd_upper,
    output logic              rd_err,
    output logic              op_accept,
    output logic              op_reject,
    output logic              ftt_we,
    output logic [FTT_W-1:0]  ftt_new,
    output logic              clr_lower,
    output logic              clr_upper,
    output logic              gsr_clr,
    output logic              fp_enabled,
    output logic              dirty_lower,
    output logic              dirty_upper
);
    localparam int NUM_OPS = 3;
    localparam int NUM_SRC = NUM_OPS - 1;
    localparam int IDX_W   = SPEC_W + 1;

    localparam int OP_LSB [NUM_OPS] = '{RS1_LSB, RS2_LSB, RD_LSB};

    logic [1:0]       op_size  [NUM_OPS];
    logic [IDX_W-1:0] op_idx   [NUM_OPS];
    logic [NUM_OPS-1:0] op_upper, op_bad, op_used;
    logic [NUM_SRC-1:0] src_zero;

    assign op_size[0] = rs1_size;
    assign op_size[1] = rs2_size;
    assign op_size[2] = rd_size;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_map
        fpdec_spec_map #(
            .INSN_W   (INSN_W),
            .FIELD_LSB(OP_LSB[g]),
            .SPEC_W   (SPEC_W)
        ) u_map (
            .instr (instr),
            .size  (op_size[g]),
            .strobe(dec_strobe),
            .idx   (op_idx[g]),
            .upper (op_upper[g]),
            .bad   (op_bad[g]),
            .used  (op_used[g])
        );
    end

    fpdec_ftt_check #(
        .FTT_W     (FTT_W),
        .FTT_BADREG(FTT_BADREG)
    ) u_ftt (
        .strobe      (dec_strobe),
        .exp_ftt     (exp_ftt),
        .stat_ftt    (stat_ftt),
        .from_illegal(from_illegal),
        .any_bad     (|op_bad),
        .accept      (op_accept),
        .reject      (op_reject),
        .ftt_we      (ftt_we),
        .ftt_new     (ftt_new)
    );

    fpdec_half_track #(
        .NUM_SRC(NUM_SRC)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (dec_strobe),
        .wr_accept(op_accept),
        .rd_used  (op_used[2]),
        .rd_upper (op_upper[2]),
        .src_used (op_used[NUM_SRC-1:0]),
        .src_upper(op_upper[NUM_SRC-1:0]),
        .src_zero (src_zero),
        .clr_lo   (clr_lower),
        .clr_hi   (clr_upper),
        .gsr_clr  (gsr_clr),
        .dirty_lo (dirty_lower),
        .dirty_hi (dirty_upper),
        .fp_en    (fp_enabled)
    );

    assign rs1_idx   = op_idx[0];
    assign rs1_upper = op_upper[0];
    assign rs1_err   = op_bad[0];
    assign rs1_zero  = src_zero[0];
    assign rs2_idx   = op_idx[1];
    assign rs2_upper = op_upper[1];
    assign rs2_err   = op_bad[1];
    assign rs2_zero  = src_zero[1];
    assign rd_idx    = op_idx[2];
    assign rd_upper  = op_upper[2];
    assign rd_err    = op_bad[2];
endmodule

// File: rtl/fp_regspec_decoder_chk.sv
module fp_regspec_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dec_strobe,
    input logic [2:0] exp_ftt,
    input logic [2:0] stat_ftt,
    input logic       from_illegal,
    input logic       rs1_err,
    input logic       rs2_err,
    input logic       rd_err,
    input logic       op_reject,
    input logic       ftt_we,
    input logic [2:0] ftt_new,
    input logic       clr_lower,
    input logic       clr_upper,
    input logic       gsr_clr,
    input logic       fp_enabled,
    input logic       dirty_lower,
    input logic       dirty_upper
);
    assert_badreg_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rs1_err || rs2_err || rd_err) && ftt_we) |-> (ftt_new == 3'd6 && op_reject));

    assert_type_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_strobe && !from_illegal && stat_ftt != exp_ftt) |-> (!ftt_we && op_reject));

    assert_clear_sets_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lower |=> dirty_lower);

    assert_clear_sets_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_upper |=> dirty_upper);

    assert_one_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_lower, clr_upper}));

    assert_dirty_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(dirty_lower) && !$fell(dirty_upper));

    assert_gsr_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gsr_clr |-> !fp_enabled);

    assert_gsr_enables_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gsr_clr |=> fp_enabled);

    assert_reject_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_reject |-> (!clr_lower && !clr_upper && !gsr_clr));

    assert_reject_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_reject |=> $stable({dirty_lower, dirty_upper, fp_enabled}));
endmodule

bind fp_regspec_decoder fp_regspec_decoder_chk u_chk (.*);

// File: tb/fp_regspec_decoder_test.sv
`timescale 1ns/1ps
module fp_regspec_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_strobe = 1'b0;
    logic [31:0] instr = '0;
    logic [1:0]  rs1_size = '0, rs2_size = '0, rd_size = '0;
    logic [2:0]  exp_ftt = '0, stat_ftt = '0;
    logic        from_illegal = 1'b0;
    logic [5:0]  rs1_idx, rs2_idx, rd_idx;
    logic        rs1_upper, rs1_err, rs1_zero, rs2_upper, rs2_err, rs2_zero;
    logic        rd_upper, rd_err, op_accept, op_reject, ftt_we;
    logic [2:0]  ftt_new;
    logic        clr_lower, clr_upper, gsr_clr, fp_enabled, dirty_lower, dirty_upper;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    fp_regspec_decoder uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [31:0] mk(input int rd, input int s1, input int s2);
        return {2'b10, 5'(rd), 6'b100011, 5'(s1), 9'h0a5, 5'(s2)};
    endfunction

    function automatic int exp_idx(input int sz, input int spec);
        if (sz == 0) return 0;
        if (sz == 1) return spec;
        return (spec % 2) * 32 + (spec - spec % 2);
    endfunction

    function automatic bit exp_bad(input int sz, input int spec);
        return (sz == 3) && ((spec / 2) % 2 == 1);
    endfunction

    task automatic apply(input int rd, input int s1, input int s2,
                         input int zd, input int z1, input int z2,
                         input int ex, input int st, input bit ill);
        @(negedge clk);
        instr = mk(rd, s1, s2);
        rd_size = 2'(zd); rs1_size = 2'(z1); rs2_size = 2'(z2);
        exp_ftt = 3'(ex); stat_ftt = 3'(st); from_illegal = ill;
        dec_strobe = 1'b1;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        dec_strobe = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        dec_strobe = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic check_state(input string req, input int lo, input int hi, input int en);
        int act;
        act = {29'd0, dirty_lower, dirty_upper, fp_enabled};
        check(act == lo * 4 + hi * 2 + en, req, act, lo * 4 + hi * 2 + en);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state and quiet request outputs
        check_state("R10", 0, 0, 0);
        check({clr_lower, clr_upper, gsr_clr} == 3'b000, "R10", int'({clr_lower, clr_upper, gsr_clr}), 0);

        // R1 R2 R3 R4: sweep of every specifier under every size
        for (int sz = 0; sz < 4; sz++) begin
            for (int sp = 0; sp < 32; sp++) begin
                int s1, s2, sd;
                bit anybad;
                s1 = sp; s2 = 31 - sp; sd = (sp * 7) % 32;
                apply(sd, s1, s2, sz, sz, sz, 3, 3, 1'b0);
                check(rs1_idx == 6'(exp_idx(sz, s1)) && rs1_upper == (exp_idx(sz, s1) >= 32)
                      && rs1_err == exp_bad(sz, s1), "R1 R3 rs1", int'(rs1_idx), exp_idx(sz, s1));
                check(rs2_idx == 6'(exp_idx(sz, s2)) && rs2_upper == (exp_idx(sz, s2) >= 32)
                      && rs2_err == exp_bad(sz, s2), "R2 R3 rs2", int'(rs2_idx), exp_idx(sz, s2));
                check(rd_idx == 6'(exp_idx(sz, sd)) && rd_upper == (exp_idx(sz, sd) >= 32)
                      && rd_err == exp_bad(sz, sd), "R3 rd", int'(rd_idx), exp_idx(sz, sd));
                anybad = exp_bad(sz, s1) || exp_bad(sz, s2) || exp_bad(sz, sd);
                check(op_reject == anybad && ftt_we && ftt_new == (anybad ? 3'd6 : 3'd0),
                      "R4 R6 ftt", int'(ftt_new), anybad ? 6 : 0);
            end
        end
        idle();

        // R5 R6 R12: trap-type gate sweep, no destination so no state change
        do_reset();
        for (int ex = 0; ex < 8; ex++) begin
            for (int st = 0; st < 8; st++) begin
                for (int il = 0; il < 2; il++) begin
                    bit pass;
                    pass = (il == 1) || (ex == st);
                    apply(0, 4, 9, 0, 1, 1, ex, st, il[0]);
                    check(op_accept == pass && op_reject == !pass && ftt_we == pass && ftt_new == 3'd0,
                          il == 1 ? "R12" : (pass ? "R6" : "R5"),
                          int'({op_accept, ftt_we}), pass ? 3 : 0);
                    check({clr_lower, clr_upper, gsr_clr} == 3'b000, "R11 no dest",
                          int'({clr_lower, clr_upper, gsr_clr}), 0);
                end
            end
        end
        idle();
        check_state("R11 no dest keeps state", 0, 0, 0);

        // R5: mismatch with a destination leaves everything untouched
        apply(5, 3, 1, 1, 1, 2, 2, 3, 1'b0);
        check({clr_lower, clr_upper, gsr_clr, ftt_we} == 4'b0000, "R5 mismatch quiet",
              int'({clr_lower, clr_upper, gsr_clr, ftt_we}), 0);
        idle();
        check_state("R5 mismatch state", 0, 0, 0);

        // R4 R11: illegal quad destination is rejected without state change
        apply(2, 0, 0, 3, 0, 0, 3, 3, 1'b0);
        check(rd_err && op_reject && ftt_we && ftt_new == 3'd6, "R4 quad rd", int'(ftt_new), 6);
        check({clr_lower, clr_upper, gsr_clr} == 3'b000, "R11 reject quiet",
              int'({clr_lower, clr_upper, gsr_clr}), 0);
        idle();
        check_state("R11 reject state", 0, 0, 0);

        // R7 R8 R9: first write to clean lower half while sources read zero
        apply(5, 3, 1, 1, 1, 2, 2, 2, 1'b0);
        check(rs1_zero && rs2_zero && rs2_upper, "R7 both clean", int'({rs1_zero, rs2_zero}), 3);
        check(clr_lower && !clr_upper, "R8 lower clear", int'({clr_lower, clr_upper}), 2);
        check(gsr_clr, "R9 gsr pulse", int'(gsr_clr), 1);
        idle();
        check_state("R8 R9 after first write", 1, 0, 1);

        // R7 R8 R9: repeat, lower now dirty, upper still clean
        apply(5, 3, 1, 1, 1, 2, 2, 2, 1'b0);
        check(!rs1_zero && rs2_zero, "R7 mixed", int'({rs1_zero, rs2_zero}), 1);
        check({clr_lower, clr_upper, gsr_clr} == 3'b000, "R8 R9 no repeat",
              int'({clr_lower, clr_upper, gsr_clr}), 0);
        idle();

        // R8: double destination with spec bit 0 set lands in upper half
        apply(1, 0, 0, 2, 0, 0, 2, 2, 1'b0);
        check(rd_upper && rd_idx == 6'd32 && clr_upper && !clr_lower && !gsr_clr, "R8 upper clear",
              int'({clr_lower, clr_upper, gsr_clr}), 2);
        idle();
        check_state("R8 both dirty", 1, 1, 1);

        // R7: no source reads zero once both halves are dirty; size none never does
        apply(0, 7, 9, 0, 3, 0, 3, 3, 1'b0);
        check(!rs1_zero && !rs2_zero, "R7 all dirty", int'({rs1_zero, rs2_zero}), 0);
        idle();

        // R7 R12: after reset, illegal-path op with mismatching type still decodes and writes
        do_reset();
        apply(9, 0, 0, 2, 0, 0, 3, 2, 1'b1);
        check(op_accept && clr_upper && gsr_clr, "R12 bypass write",
              int'({op_accept, clr_upper, gsr_clr}), 7);
        idle();
        check_state("R12 bypass state", 0, 1, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule